// File: doc/BRIEF.md
# Multiplexed Address/Data Bus RAM Slave with Wait-State Control

This block sits on a 16-bit processor bus whose low sixteen address bits share wires with the data bits. During the first clock of each bus cycle the master raises an address latch strobe, and the block captures the full 20-bit address together with the active-low byte-high enable and the memory/IO status. From the captured upper address bits it decides whether the cycle targets its memory page. It then serves the cycle from two byte-wide RAM banks: an even bank on the low data lanes and an odd bank on the high lanes.

Slow memory is modelled by holding READY low for a parameterised number of clocks once a read or write strobe becomes active, so the master inserts that many wait states before finishing the cycle. Writes are committed when the write strobe returns high. Reads drive only the selected byte lanes and return zero on any lane that was not selected. Data-direction and data-enable outputs are produced for an external bus transceiver.

Top module: `muxbus_ram_if`

## Requirements
- R1: After reset, with no cycle in progress, ready is 1, denN is 1, adOe is 0 and dtR is 1.
- R2: The address is taken from {addrHi, adIn} and bheN and mio are sampled on each rising clock edge where ale is 1. Later changes on adIn, such as write data replacing the address, do not move the location being accessed.
- R3: A cycle hits only when the latched mio is 1 and latched address bits 19..12 equal BASE_PAGE (default 8'h3C). On a miss, ready stays 1, adOe stays 0, denN stays 1 and no bank is written.
- R4: The even bank sits on adIn/adOut bits 7..0 and is selected when latched address bit 0 is 0. The odd bank sits on bits 15..8 and is selected when latched bheN is 0. Both banks are indexed by latched address bits 11..1.
- R5: On a hit, ready is 0 during the first WAIT_STATES (default 2) clocks in which a strobe is active and ale is 0, and is 1 after that for the rest of the cycle.
- R6: A write is committed on the first rising clock edge at which wrN is seen high after being low. It stores adIn only into the selected banks, and an unselected bank keeps its contents.
- R7: During a hit read (rdN 0, ale 0), adOe is 1 and each selected lane returns the stored byte. An unselected lane returns 0, and with both banks selected the full 16-bit word is returned.
- R8: dtR is 0 (receive) while a hit read strobe is active and 1 (transmit) otherwise. denN is 0 only on a hit while a strobe is active and ale is 0.
- R9: A cycle with mio 0 (IO space) is ignored: no wait state is inserted, no data is driven and the RAM contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address latch strobe, high during the first clock of a cycle |
| mio | input | 1 | 1 = memory space, 0 = IO space |
| bheN | input | 1 | Active-low byte-high enable |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| addrHi | input | 4 | Address bits 19..16 |
| adIn | input | 16 | Multiplexed address/data lines from the master |
| adOut | output | 16 | Read data toward the master |
| adOe | output | 1 | Drive enable for adOut |
| ready | output | 1 | Low inserts a wait state |
| dtR | output | 1 | Transceiver direction, 1 = transmit, 0 = receive |
| denN | output | 1 | Active-low transceiver enable |

## Verification
Assertions check four things on every cycle: the wait counter never exceeds its limit and counts down one step per stalled clock, the transceiver stays disabled while the address is latched, the bus is never driven in transmit direction, and ready never drops on a miss. Other behaviour is visible only through the bench's bus cycles. These cover the exact number of wait states seen by the master, byte-lane steering for every combination of address bit 0 and byte-high enable, zeroed unselected lanes, and writes that must leave the other bank untouched. They also cover IO-space and off-page cycles, which must leave memory unchanged when it is read back later.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchAddr;  // capture address/status this edge
    logic wrLo;       // commit low lane
    logic wrHi;       // commit high lane
    logic rdLo;       // drive low lane
    logic rdHi;       // drive high lane
  } busStrb_t;

endpackage

// File: rtl/muxbus_dp.sv
module muxbus_dp
  import muxbus_pkg::*;
#(
  parameter int BANK_AW = 11,
  parameter int ADDR_W  = 20,
  parameter logic [ADDR_W-BANK_AW-2:0] BASE_PAGE = '1
) (
  input  logic        clk,
  input  logic        rstN,
  input  busStrb_t    strb,
  input  logic        mio,
  input  logic        bheN,
  input  logic [ADDR_W-17:0] addrHi,
  input  logic [15:0] adIn,
  output logic        hit,
  output logic        a0,
  output logic        bheLat,
  output logic [15:0] adOut
);

  localparam int PAGE_LSB = BANK_AW + 1;
  localparam int DEPTH    = 1 << BANK_AW;
  localparam int LANES    = 2;

  logic [ADDR_W-1:0]  addrLat;
  logic               mioLat;
  logic [BANK_AW-1:0] idx;
  logic [LANES-1:0]   wrEn;
  logic [LANES-1:0]   rdEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLat <= '0;
      mioLat  <= 1'b0;
      bheLat  <= 1'b1;
    end else if (strb.latchAddr) begin
      addrLat <= {addrHi, adIn};
      mioLat  <= mio;
      bheLat  <= bheN;
    end
  end

  assign hit  = mioLat && (addrLat[ADDR_W-1:PAGE_LSB] == BASE_PAGE);
  assign a0   = addrLat[0];
  assign idx  = addrLat[BANK_AW:1];
  assign wrEn = {strb.wrHi, strb.wrLo};
  assign rdEn = {strb.rdHi, strb.rdLo};

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wrEn[g]) mem[idx] <= adIn[8*g +: 8];
    end

    assign adOut[8*g +: 8] = rdEn[g] ? mem[idx] : 8'h00;
  end

  // Decode result only changes when a new address is captured
  AST_HIT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchAddr |=> $stable(hit)); // R2

  // No lane is written outside a hit cycle
  AST_NO_WRITE_MISS: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> !(wrEn[0] || wrEn[1])); // R3

endmodule

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl
  import muxbus_pkg::*;
#(
  parameter int WAIT_STATES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     ale,
  input  logic     rdN,
  input  logic     wrN,
  input  logic     hit,
  input  logic     a0,
  input  logic     bheLat,
  output busStrb_t strb,
  output logic     ready,
  output logic     dtR,
  output logic     denN,
  output logic     adOe
);

  localparam int WAIT_W = (WAIT_STATES < 1) ? 1 : $clog2(WAIT_STATES + 1);
  localparam logic [WAIT_W-1:0] WAIT_LOAD = WAIT_W'(WAIT_STATES);

  logic [WAIT_W-1:0] waitCnt;
  logic              wrPrev;
  logic              loSel;
  logic              hiSel;
  logic              cycActive;
  logic              rdActive;
  logic              wrRise;

  assign loSel     = !a0;
  assign hiSel     = !bheLat;
  assign cycActive = hit && !ale && (!rdN || !wrN);
  assign rdActive  = hit && !ale && !rdN;
  assign wrRise    = hit && !wrPrev && wrN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
      wrPrev  <= 1'b1;
    end else begin
      wrPrev <= wrN;
      if (ale) waitCnt <= WAIT_LOAD;
      else if (cycActive && (waitCnt != '0)) waitCnt <= waitCnt - WAIT_W'(1);
    end
  end

  assign ready = !(cycActive && (waitCnt != '0));

  always_comb begin
    strb.latchAddr = ale;
    strb.wrLo      = wrRise && loSel;
    strb.wrHi      = wrRise && hiSel;
    strb.rdLo      = rdActive && loSel;
    strb.rdHi      = rdActive && hiSel;
  end

  assign adOe = rdActive;
  assign dtR  = !rdActive;
  assign denN = !cycActive;

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    waitCnt <= WAIT_LOAD); // R5

  AST_WAIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cycActive && !ready) |=> (ale || (waitCnt == $past(waitCnt) - WAIT_W'(1)))); // R5

  AST_DEN_OFF_ALE: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> denN); // R8

  AST_OE_RECEIVE: assert property (@(posedge clk) disable iff (!rstN)
    adOe |-> !dtR); // R7

  AST_MISS_READY: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (ready && denN)); // R3

endmodule

// File: rtl/muxbus_ram_if.sv
module muxbus_ram_if
  import muxbus_pkg::*;
#(
  parameter int WAIT_STATES = 2,
  parameter int BANK_AW     = 11,
  parameter logic [7:0] BASE_PAGE = 8'h3C
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ale,
  input  logic        mio,
  input  logic        bheN,
  input  logic        rdN,
  input  logic        wrN,
  input  logic [3:0]  addrHi,
  input  logic [15:0] adIn,
  output logic [15:0] adOut,
  output logic        adOe,
  output logic        ready,
  output logic        dtR,
  output logic        denN
);

  busStrb_t strb;
  logic     hit;
  logic     a0;
  logic     bheLat;

  muxbus_ctrl #(.WAIT_STATES(WAIT_STATES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .ale    (ale),
    .rdN    (rdN),
    .wrN    (wrN),
    .hit    (hit),
    .a0     (a0),
    .bheLat (bheLat),
    .strb   (strb),
    .ready  (ready),
    .dtR    (dtR),
    .denN   (denN),
    .adOe   (adOe)
  );

  muxbus_dp #(
    .BANK_AW   (BANK_AW),
    .ADDR_W    (20),
    .BASE_PAGE (BASE_PAGE[19-BANK_AW-1:0])
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .mio    (mio),
    .bheN   (bheN),
    .addrHi (addrHi),
    .adIn   (adIn),
    .hit    (hit),
    .a0     (a0),
    .bheLat (bheLat),
    .adOut  (adOut)
  );

endmodule

// File: tb/muxbus_ram_if_bench.sv
module muxbus_ram_if_bench;

  localparam int WAITS = 2;
  localparam logic [7:0] BASE = 8'h3C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ale = 1'b0;
  logic        mio = 1'b0;
  logic        bheN = 1'b1;
  logic        rdN = 1'b1;
  logic        wrN = 1'b1;
  logic [3:0]  addrHi = '0;
  logic [15:0] adIn = '0;
  logic [15:0] adOut;
  logic        adOe, ready, dtR, denN;

  int checks = 0;
  int fails = 0;

  logic [7:0] mLo [2048];
  logic [7:0] mHi [2048];

  logic [15:0] sData;
  logic        sOe, sDt, sDen;
  int          sWaits;

  always #5 clk = ~clk;

  muxbus_ram_if #(.WAIT_STATES(WAITS), .BANK_AW(11), .BASE_PAGE(BASE)) u_muxbus_ram_if (
    .clk(clk), .rstN(rstN), .ale(ale), .mio(mio), .bheN(bheN), .rdN(rdN), .wrN(wrN),
    .addrHi(addrHi), .adIn(adIn), .adOut(adOut), .adOe(adOe), .ready(ready),
    .dtR(dtR), .denN(denN)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit isHit(input logic [19:0] a, input bit m);
    return m && (a[19:12] == BASE);
  endfunction

  function automatic logic [15:0] expRead(input logic [19:0] a, input bit bhe);
    logic [15:0] r;
    r[7:0]  = !a[0] ? mLo[a[11:1]] : 8'h00;
    r[15:8] = !bhe  ? mHi[a[11:1]] : 8'h00;
    return r;
  endfunction

  // One full bus cycle; samples ready count and data-phase outputs
  task automatic busCycle(input bit isWr, input logic [19:0] a, input bit bhe, input bit m,
                          input logic [15:0] wd);
    @(negedge clk);
    ale = 1'b1; mio = m; bheN = bhe; addrHi = a[19:16]; adIn = a[15:0];
    @(negedge clk);
    ale = 1'b0;
    if (isWr) begin adIn = wd; wrN = 1'b0; end
    else begin adIn = 16'h0000; rdN = 1'b0; end
    #1;
    sWaits = 0;
    while (!ready && sWaits < 64) begin
      sWaits++;
      @(negedge clk);
      #1;
    end
    sData = adOut; sOe = adOe; sDt = dtR; sDen = denN;
    @(negedge clk);
    rdN = 1'b1; wrN = 1'b1;
    @(negedge clk);
    adIn = 16'h0000;
  endtask

  task automatic doWrite(input logic [19:0] a, input bit bhe, input bit m, input logic [15:0] wd);
    bit h;
    h = isHit(a, m);
    busCycle(1'b1, a, bhe, m, wd);
    check(sWaits == (h ? WAITS : 0), "R5 write wait count", sWaits, h ? WAITS : 0);
    check(sDen == !h, "R8 write denN", sDen, !h);
    check(sDt == 1'b1 && sOe == 1'b0, "R8 write dtR/adOe", {sDt, sOe}, 2'b10);
    if (h) begin
      if (!a[0]) mLo[a[11:1]] = wd[7:0];
      if (!bhe)  mHi[a[11:1]] = wd[15:8];
    end
  endtask

  task automatic doRead(input logic [19:0] a, input bit bhe, input bit m, input string tag);
    bit h;
    logic [15:0] e;
    h = isHit(a, m);
    e = h ? expRead(a, bhe) : 16'h0000;
    busCycle(1'b0, a, bhe, m, 16'h0000);
    check(sWaits == (h ? WAITS : 0), "R5 read wait count", sWaits, h ? WAITS : 0);
    check(sOe == h, "R7 read adOe", sOe, h);
    check(sDt == !h && sDen == !h, "R8 read dtR/denN", {sDt, sDen}, {!h, !h});
    check(sData == e, tag, sData, e);
  endtask

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [19:0] a;
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(ready && denN && !adOe && dtR, "R1 reset outputs", {ready, denN, adOe, dtR}, 4'b1101);

    // Pre-load 32 words with full-word writes (R4 both lanes)
    for (int i = 0; i < 32; i++) begin
      a = {BASE, 11'((i < 16) ? i : 1024 + i - 16), 1'b0};
      doWrite(a, 1'b0, 1'b1, 16'hA000 ^ 16'(i * 16'h0131));
    end

    // R2: data differs from address; read back at captured location
    a = {BASE, 11'd3, 1'b0};
    doWrite(a, 1'b0, 1'b1, 16'hFFFF);
    doRead(a, 1'b0, 1'b1, "R2 latched address holds");
    doRead({BASE, 11'd4, 1'b0}, 1'b0, 1'b1, "R2 neighbour untouched");

    // R4/R6: byte-lane writes
    doWrite({BASE, 11'd5, 1'b0}, 1'b1, 1'b1, 16'h1122);
    doRead({BASE, 11'd5, 1'b0}, 1'b0, 1'b1, "R6 low-only write");
    doWrite({BASE, 11'd5, 1'b1}, 1'b0, 1'b1, 16'h3344);
    doRead({BASE, 11'd5, 1'b0}, 1'b0, 1'b1, "R6 high-only write");
    doWrite({BASE, 11'd6, 1'b1}, 1'b1, 1'b1, 16'h5566);
    doRead({BASE, 11'd6, 1'b0}, 1'b0, 1'b1, "R6 no-lane write");
    doRead({BASE, 11'd6, 1'b1}, 1'b1, 1'b1, "R7 no-lane read zero");
    doRead({BASE, 11'd6, 1'b1}, 1'b0, 1'b1, "R4 high lane only");
    doRead({BASE, 11'd6, 1'b0}, 1'b1, 1'b1, "R4 low lane only");

    // R9: IO-space write ignored
    doWrite({BASE, 11'd7, 1'b0}, 1'b0, 1'b0, 16'hDEAD);
    doRead({BASE, 11'd7, 1'b0}, 1'b0, 1'b0, "R9 IO read no drive");
    doRead({BASE, 11'd7, 1'b0}, 1'b0, 1'b1, "R9 IO write left memory");

    // R3: off-page write ignored
    doWrite({8'h3D, 11'd8, 1'b0}, 1'b0, 1'b1, 16'hBEEF);
    doRead({BASE, 11'd8, 1'b0}, 1'b0, 1'b1, "R3 miss write left memory");
    doRead({8'h3D, 11'd8, 1'b0}, 1'b0, 1'b1, "R3 miss read zero");

    // Random mix
    for (int n = 0; n < 300; n++) begin
      logic [31:0] u;
      logic [7:0]  pg;
      logic [10:0] ix;
      bit          m;
      u  = $urandom;
      pg = (u[7:5] == 3'd0) ? 8'($urandom) : BASE;
      m  = (u[10:8] != 3'd0);
      ix = 11'(u[4:1]) + (u[0] ? 11'd1024 : 11'd0);
      a  = {pg, ix, u[11]};
      if (u[13]) doWrite(a, u[12], m, 16'($urandom));
      else       doRead(a, u[12], m, "R7 random read data");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule